// File: doc/BRIEF.md
# Staged Multi-Mode Barrel Shifter

This block shifts a 16-bit operand by any amount from 0 to 15 positions, in one of four shift types selected by a 2-bit opcode. It is purely combinational, so the result follows the inputs within the same cycle. It is intended to sit in a processor's execution datapath, next to the adder and logic units.

The shift is built from a cascade of fixed stages that shift by 1, 2, 4 and 8 positions. Each stage is enabled by the count bit of matching weight, so the stage shifts add up to the requested amount. A small control module decodes the opcode into two things: a direction, and a fill bit taken from the original operand. Every stage uses that same fill bit. The right-shift types therefore always fill from the unshifted word, never from partial results.

Top module: `barrel_shift_unit`

## Requirements
- R1: When `shiftCnt` is 0, `dataOut` equals `dataIn` for every opcode.
- R2: The `shiftOp` encoding is 2'b00 logical left, 2'b01 logical right, 2'b10 arithmetic right, and 2'b11 right with low-bit fill.
- R3: Logical left (2'b00) moves every bit up by `shiftCnt` positions and fills the vacated low bits with 0.
- R4: Logical right (2'b01) moves every bit down by `shiftCnt` positions and fills the vacated high bits with 0.
- R5: Arithmetic right (2'b10) moves every bit down by `shiftCnt` positions and fills the vacated high bits with the original `dataIn[15]`.
- R6: Low-bit-fill right (2'b11) moves every bit down by `shiftCnt` positions and fills the vacated high bits with the original `dataIn[0]`.
- R7: Count bits 0, 1, 2 and 3 weigh 1, 2, 4 and 8 positions. Any count from 0 to 15 gives the shift equal to the sum of its set bits.
- R8: `dataOut` is a combinational function of the inputs. It settles within the same cycle, with no clock or state involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | 16 | Operand to be shifted |
| shiftCnt | input | 4 | Shift amount, 0 to 15 |
| shiftOp | input | 2 | Shift type selector |
| dataOut | output | 16 | Shifted result |

## Verification
The hardest case to expose is the low-bit-fill right shift when several stages are enabled at once. A design that took its fill bit from an intermediate stage would copy a bit that an earlier stage had already moved into position 0, rather than the original bit 0. To catch this, the stimulus uses operands whose bit 0 differs from bits 1, 2, 4 and 8. It then sweeps every count under every opcode, so each mix of enabled stages is reached with a misleading intermediate bit 0. Operands whose bit 15 and bit 0 disagree keep the arithmetic fill and the low-bit fill apart.

// File: rtl/shift_pkg.sv
package shift_pkg;
  typedef enum logic [1:0] {
    OP_LSL = 2'b00,
    OP_LSR = 2'b01,
    OP_ASR = 2'b10,
    OP_XSR = 2'b11
  } shiftOpT;

  typedef struct packed {
    logic goRight;
    logic fillBit;
  } shiftCtrlT;
endpackage

// File: rtl/shift_ctrl.sv
module shift_ctrl
  import shift_pkg::*;
(
  input  logic [1:0] opCode,
  input  logic       srcMsb,
  input  logic       srcLsb,
  output shiftCtrlT  strobes
);
  shiftOpT opDec;

  always_comb begin
    opDec = shiftOpT'(opCode);
    strobes.goRight = 1'b1;
    strobes.fillBit = 1'b0;
    unique case (opDec)
      OP_LSL: strobes.goRight = 1'b0;
      OP_LSR: strobes.fillBit = 1'b0;
      OP_ASR: strobes.fillBit = srcMsb;
      OP_XSR: strobes.fillBit = srcLsb;
      default: strobes.goRight = 1'b0;
    endcase
  end
endmodule

// File: rtl/shift_stage.sv
module shift_stage #(
  parameter int W   = 16,
  parameter int AMT = 1
) (
  input  logic [W-1:0] dIn,
  input  logic         en,
  input  logic         goRight,
  input  logic         fillBit,
  output logic [W-1:0] dOut
);
  always_comb begin
    if (!en)
      dOut = dIn;
    else if (goRight)
      dOut = {{AMT{fillBit}}, dIn[W-1:AMT]};
    else
      dOut = {dIn[W-AMT-1:0], {AMT{1'b0}}};
  end
endmodule

// File: rtl/shift_datapath.sv
module shift_datapath
  import shift_pkg::*;
#(
  parameter int W      = 16,
  parameter int STAGES = 4
) (
  input  logic [W-1:0]      dIn,
  input  logic [STAGES-1:0] cnt,
  input  shiftCtrlT         strobes,
  output logic [W-1:0]      dOut
);
  logic [W-1:0] chain [0:STAGES];

  assign chain[0] = dIn;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : gStage
      shift_stage #(.W(W), .AMT(1 << g)) uStage (
        .dIn    (chain[g]),
        .en     (cnt[g]),
        .goRight(strobes.goRight),
        .fillBit(strobes.fillBit),
        .dOut   (chain[g+1])
      );
    end
  endgenerate

  assign dOut = chain[STAGES];
endmodule

// File: rtl/barrel_shift_unit.sv
module barrel_shift_unit
  import shift_pkg::*;
#(
  parameter int W = 16,
  localparam int CW = $clog2(W)
) (
  input  logic [W-1:0]  dataIn,
  input  logic [CW-1:0] shiftCnt,
  input  logic [1:0]    shiftOp,
  output logic [W-1:0]  dataOut
);
  shiftCtrlT strobes;

  shift_ctrl uCtrl (
    .opCode (shiftOp),
    .srcMsb (dataIn[W-1]),
    .srcLsb (dataIn[0]),
    .strobes(strobes)
  );

  shift_datapath #(.W(W), .STAGES(CW)) uPath (
    .dIn    (dataIn),
    .cnt    (shiftCnt),
    .strobes(strobes),
    .dOut   (dataOut)
  );

  logic [W-1:0] lowMask;
  logic [W-1:0] highMask;

  always_comb begin
    lowMask  = (W'(1) << shiftCnt) - W'(1);
    highMask = ~({W{1'b1}} >> shiftCnt);
    // R1
    zero_count_chk: assert (shiftCnt != '0 || dataOut == dataIn);
    // R3
    lsl_fill_chk: assert (shiftOp != 2'b00 || (dataOut & lowMask) == '0);
    // R4
    lsr_fill_chk: assert (shiftOp != 2'b01 || (dataOut & highMask) == '0);
    // R5
    asr_fill_chk: assert (shiftOp != 2'b10 ||
                          (dataOut & highMask) == (dataIn[W-1] ? highMask : '0));
    // R6
    xsr_fill_chk: assert (shiftOp != 2'b11 ||
                          (dataOut & highMask) == (dataIn[0] ? highMask : '0));
  end
endmodule

// File: tb/tb_barrel_shift_unit.sv
module tb_barrel_shift_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic [15:0] dataIn;
  logic [3:0]  shiftCnt;
  logic [1:0]  shiftOp;
  logic [15:0] dataOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  barrel_shift_unit dut (
    .dataIn  (dataIn),
    .shiftCnt(shiftCnt),
    .shiftOp (shiftOp),
    .dataOut (dataOut)
  );

  localparam int NV = 18;
  localparam logic [15:0] vIn  [NV] = '{
    16'h8001, 16'h8001, 16'h8001, 16'h8001,
    16'h1234, 16'h1234, 16'h1234, 16'h1234,
    16'hF0F1, 16'hF0F1, 16'hF0F1, 16'hF0F1,
    16'h7FFE, 16'h7FFE, 16'h7FFE,
    16'hA5A5, 16'hA5A5, 16'hA5A5};
  localparam logic [3:0]  vCnt [NV] = '{
    4'd1, 4'd1, 4'd1, 4'd1,
    4'd4, 4'd4, 4'd4, 4'd4,
    4'd15, 4'd15, 4'd15, 4'd15,
    4'd15, 4'd3, 4'd8,
    4'd0, 4'd0, 4'd0};
  localparam logic [1:0]  vOp  [NV] = '{
    2'd0, 2'd1, 2'd2, 2'd3,
    2'd0, 2'd1, 2'd2, 2'd3,
    2'd0, 2'd1, 2'd2, 2'd3,
    2'd2, 2'd3, 2'd0,
    2'd1, 2'd2, 2'd3};
  localparam logic [15:0] vExp [NV] = '{
    16'h0002, 16'h4000, 16'hC000, 16'hC000,
    16'h2340, 16'h0123, 16'h0123, 16'h0123,
    16'h8000, 16'h0001, 16'hFFFF, 16'hFFFF,
    16'h0000, 16'h0FFF, 16'hFE00,
    16'hA5A5, 16'hA5A5, 16'hA5A5};

  function automatic logic [15:0] refShift(input logic [15:0] d, input int n, input int op);
    logic [15:0] r;
    logic fill;
    fill = (op == 2) ? d[15] : (op == 3) ? d[0] : 1'b0;
    for (int i = 0; i < 16; i++) begin
      if (op == 0) r[i] = (i - n >= 0) ? d[i-n] : 1'b0;
      else         r[i] = (i + n < 16) ? d[i+n] : fill;
    end
    return r;
  endfunction

  task automatic check(input string req, input logic [15:0] exp);
    checks++;
    if (dataOut !== exp) begin
      errors++;
      $display("FAIL %s in=%h cnt=%0d op=%0d got=%h exp=%h",
               req, dataIn, shiftCnt, shiftOp, dataOut, exp);
    end
  endtask

  task automatic apply(input logic [15:0] d, input logic [3:0] c, input logic [1:0] o);
    @(posedge clk);
    dataIn = d; shiftCnt = c; shiftOp = o;
    @(negedge clk);
  endtask

  initial begin
    dataIn = 16'h0; shiftCnt = 4'd0; shiftOp = 2'd0;
    @(negedge clk);
    check("R1 initial", 16'h0000);

    for (int k = 0; k < NV; k++) begin
      apply(vIn[k], vCnt[k], vOp[k]);
      case (vOp[k])
        2'd0: check("R3 R2 table", vExp[k]);
        2'd1: check("R4 R2 table", vExp[k]);
        2'd2: check("R5 R2 table", vExp[k]);
        default: check("R6 R2 table", vExp[k]);
      endcase
    end

    // R8: output follows input change without any clock edge
    apply(16'h00F0, 4'd4, 2'd1);
    #3 dataIn = 16'h0F00;
    #2 check("R8 comb", 16'h00F0);

    // R1: zero count, all opcodes, awkward data
    for (int o = 0; o < 4; o++) begin
      apply(16'h8116, 4'd0, 2'(o));
      check("R1 zero count", 16'h8116);
    end

    // R7 R6 R5: full count sweep on fill-sensitive operands
    begin
      logic [15:0] pats [4];
      pats[0] = 16'h0001; pats[1] = 16'h7EEF; pats[2] = 16'h8116; pats[3] = 16'hFEFE;
      for (int p = 0; p < 4; p++)
        for (int o = 0; o < 4; o++)
          for (int c = 0; c < 16; c++) begin
            apply(pats[p], 4'(c), 2'(o));
            check("R7 sweep", refShift(pats[p], c, o));
          end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule